// File: doc/BRIEF.md
# Multi-Channel Clock Generator and Peripheral Clock Router

This block produces a small set of generator clocks and routes them to peripheral clock consumers. All clocks are modelled as single-cycle enable pulses on one reference clock `clk`. Each of four generator channels picks one of eight tick sources, optionally divides it, and gates the result with its own enable. Channel 0 feeds the main system clock enable. Channel 1 may serve as a source for the other channels. Every channel owns one pad, which either supplies ticks to that channel or carries the channel's ticks outward.

Software configures a channel with a single 16-bit write to the generator port. It maps a peripheral clock onto a channel with a single 16-bit write to the clock-map port, which carries both the entry index and the channel select. Both kinds of entry carry a lock bit. A locked entry ignores further writes and survives a software reset. Only the hardware reset `rst` clears a lock. No global enable exists: each channel and entry runs on its own bits.

Top module: `gclk_ctrl`

## Requirements
- R1: After `rst`, channel 0 is enabled on source 0 with no division, and channels 1 to 3 are disabled. All pads are inputs, and every clock-map entry selects channel 0 with its enable and lock cleared.
- R2: The source codes in generator write bits [2:0] are as follows. Codes 0 to 5 select `src_tick[code]`. Code 6 selects the channel's own pad input, which reads as 0 while that pad is driven outward. Code 7 selects the output of channel 1.
- R3: With divide mode off (generator write bit 3 = 0) and the channel enabled, `gen_tick[g]` is high in the cycle after each cycle in which the selected source is high.
- R4: With divide mode on and a divide value N ≥ 2 (generator write bits [15:8]), the channel emits one pulse for every N source ticks, on the Nth tick counted from the write. A value of 0 or 1 divides by one.
- R5: Generator write bit 4 enables the channel. `gen_active[g]` shows the new value in the cycle after the write. A disabled channel holds `gen_tick[g]` low from the following cycle.
- R6: A generator write to channel 1 with source code 7 is ignored entirely.
- R7: Generator write bit 5 drives the pad outward. `gen_pad_oe[g]` equals that bit, and `gen_pad_out[g]` equals `gen_tick[g]` while the pad is driven.
- R8: A clock-map write carries the entry index in bits [5:0], the channel in bits [11:8], the enable in bit 14 and the lock in bit 15. `clk_en[i]` equals the entry's enable ANDed with the selected channel's `gen_tick`. A write with index ≥ 8 or channel ≥ 4 is ignored.
- R9: A write to a generator (bit 6 set) or clock-map entry whose lock bit is set is ignored.
- R10: A one-cycle `swrst` restores every unlocked channel and entry to its R1 state and leaves locked ones unchanged. Only `rst` clears a lock bit.
- R11: `main_clk_en` equals `gen_tick[0]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| swrst | input | 1 | Software reset request, one cycle |
| gen_we | input | 1 | Generator configuration write strobe |
| gen_wid | input | 2 | Target channel of the generator write |
| gen_wdata | input | 16 | Generator configuration word |
| clk_we | input | 1 | Clock-map write strobe |
| clk_wdata | input | 16 | Clock-map word: index, channel, enable, lock |
| src_tick | input | 6 | Shared source tick inputs, codes 0 to 5 |
| gen_pad_in | input | 4 | Per-channel pad inputs |
| gen_pad_out | output | 4 | Per-channel pad output value |
| gen_pad_oe | output | 4 | Per-channel pad output enable |
| gen_tick | output | 4 | Per-channel generator tick |
| gen_active | output | 4 | Per-channel enable state |
| main_clk_en | output | 1 | Main system clock enable (channel 0) |
| clk_en | output | 8 | Peripheral clock enables |

## Verification
The bench first steers the corner cases directly, then compares every output against a behavioural model on every cycle while writes, locks and resets arrive at random. It covers channel 1 trying to select itself, which a faulty design would accept, leaving channel 1 fed by its own output. It covers a pad that is both selected as a source and driven outward, which a faulty design would let loop its own ticks back. It covers division by 0, 1 and 3, where an off-by-one counter would give the wrong pulse rate. It covers writes with an out-of-range index or channel, which a faulty design would accept, enabling a nonexistent mapping. It also checks that locked entries survive a software reset, which a faulty design would wipe, and that the hardware reset then frees them.

// File: rtl/gclk_pkg.sv
package gclk_pkg;

    localparam int NUM_GEN  = 4;
    localparam int NUM_SRC  = 8;
    localparam int NUM_EXT  = NUM_SRC - 2;
    localparam int NUM_CLK  = 8;
    localparam int DIV_W    = 8;
    localparam int CFG_W    = 16;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int GEN_IDW  = $clog2(NUM_GEN);
    localparam int CLK_IDW  = 6;
    localparam int GSEL_W   = 4;

    localparam logic [SRC_W-1:0] SRC_PAD  = SRC_W'(NUM_SRC - 2);
    localparam logic [SRC_W-1:0] SRC_GEN1 = SRC_W'(NUM_SRC - 1);

    typedef struct packed {
        logic             lock;
        logic             pad_drive;
        logic             enable;
        logic             divsel;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } gen_cfg_t;

    typedef struct packed {
        logic               lock;
        logic               enable;
        logic [GEN_IDW-1:0] gen;
    } clk_ent_t;

    function automatic gen_cfg_t decode_gen(input logic [CFG_W-1:0] w);
        gen_cfg_t c;
        c.src       = w[2:0];
        c.divsel    = w[3];
        c.enable    = w[4];
        c.pad_drive = w[5];
        c.lock      = w[6];
        c.div       = w[15:8];
        return c;
    endfunction

    function automatic gen_cfg_t gen_default(input logic is_main);
        gen_cfg_t c;
        c        = '0;
        c.enable = is_main;
        return c;
    endfunction

endpackage

// File: rtl/gclk_gen_channel.sv
module gclk_gen_channel
    import gclk_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               swrst,
    input  logic               we,
    input  gen_cfg_t           wcfg,
    input  logic [NUM_EXT-1:0] ext_tick,
    input  logic               pad_in,
    input  logic               gen1_tick,
    output logic               tick,
    output logic               active,
    output logic               pad_oe,
    output logic               pad_out
);

    localparam logic IS_MAIN = (IDX == 0);
    localparam logic IS_GEN1 = (IDX == 1);

    gen_cfg_t           cfg_q;
    logic [DIV_W-1:0]   cnt_q;
    logic [NUM_SRC-1:0] src_vec;
    logic               sel_tick, div_on, last, wipe, accept, self_ok;

    always_comb begin
        src_vec  = {gen1_tick, pad_in & ~cfg_q.pad_drive, ext_tick};
        sel_tick = src_vec[cfg_q.src];
        div_on   = cfg_q.divsel && (cfg_q.div > DIV_W'(1));
        last     = (cnt_q == cfg_q.div - DIV_W'(1));
        wipe     = swrst && !cfg_q.lock;
        self_ok  = !(IS_GEN1 && (wcfg.src == SRC_GEN1));
        accept   = we && !cfg_q.lock && self_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= gen_default(IS_MAIN);
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= cfg_q.enable & (div_on ? (sel_tick & last) : sel_tick);
            if (wipe)
                cfg_q <= gen_default(IS_MAIN);
            else if (accept)
                cfg_q <= wcfg;
            if (wipe || accept)
                cnt_q <= '0;
            else if (sel_tick && div_on)
                cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
        end
    end

    assign active  = cfg_q.enable;
    assign pad_oe  = cfg_q.pad_drive;
    assign pad_out = cfg_q.pad_drive & tick;

    // R5: a disabled channel produces no tick on the next cycle
    a_r5_gated_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.enable |=> !tick);

    // R4: divider count always stays below the divide value
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        div_on |-> (cnt_q < cfg_q.div));

    // R9 R10: a locked configuration never changes until hardware reset
    a_r9_gen_locked: assert property (@(posedge clk) disable iff (rst)
        cfg_q.lock |=> $stable(cfg_q));

    generate
        if (IS_GEN1) begin : g_self_guard
            // R6: channel 1 never holds its own output as source
            a_r6_no_self_src: assert property (@(posedge clk) disable iff (rst)
                cfg_q.src != SRC_GEN1);
        end
    endgenerate

endmodule

// File: rtl/gclk_clk_map.sv
module gclk_clk_map
    import gclk_pkg::*;
#(
    parameter int NCLK = NUM_CLK,
    parameter int NGEN = NUM_GEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             swrst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic [NGEN-1:0]  gen_tick,
    output logic [NCLK-1:0]  clk_en
);

    logic [CLK_IDW-1:0] wid;
    logic [GSEL_W-1:0]  wgen;
    logic               fields_ok;
    clk_ent_t           wnew;

    always_comb begin
        wid         = wdata[5:0];
        wgen        = wdata[11:8];
        fields_ok   = (wid < CLK_IDW'(NCLK)) && (wgen < GSEL_W'(NGEN));
        wnew.lock   = wdata[15];
        wnew.enable = wdata[14];
        wnew.gen    = wgen[GEN_IDW-1:0];
    end

    generate
        for (genvar i = 0; i < NCLK; i++) begin : g_ent
            clk_ent_t ent_q;

            always_ff @(posedge clk) begin
                if (rst)
                    ent_q <= '0;
                else if (swrst && !ent_q.lock)
                    ent_q <= '0;
                else if (we && fields_ok && (wid == CLK_IDW'(i)) && !ent_q.lock)
                    ent_q <= wnew;
            end

            assign clk_en[i] = ent_q.enable & gen_tick[ent_q.gen];

            // R9 R10: a locked map entry holds until hardware reset
            a_r9_map_locked: assert property (@(posedge clk) disable iff (rst)
                ent_q.lock |=> $stable(ent_q));
        end
    endgenerate

endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
    import gclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               swrst,
    input  logic               gen_we,
    input  logic [GEN_IDW-1:0] gen_wid,
    input  logic [CFG_W-1:0]   gen_wdata,
    input  logic               clk_we,
    input  logic [CFG_W-1:0]   clk_wdata,
    input  logic [NUM_EXT-1:0] src_tick,
    input  logic [NUM_GEN-1:0] gen_pad_in,
    output logic [NUM_GEN-1:0] gen_pad_out,
    output logic [NUM_GEN-1:0] gen_pad_oe,
    output logic [NUM_GEN-1:0] gen_tick,
    output logic [NUM_GEN-1:0] gen_active,
    output logic               main_clk_en,
    output logic [NUM_CLK-1:0] clk_en
);

    gen_cfg_t wcfg;

    assign wcfg = decode_gen(gen_wdata);

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
            gclk_gen_channel #(.IDX(g)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .swrst     (swrst),
                .we        (gen_we && (gen_wid == GEN_IDW'(g))),
                .wcfg      (wcfg),
                .ext_tick  (src_tick),
                .pad_in    (gen_pad_in[g]),
                .gen1_tick (gen_tick[1]),
                .tick      (gen_tick[g]),
                .active    (gen_active[g]),
                .pad_oe    (gen_pad_oe[g]),
                .pad_out   (gen_pad_out[g])
            );
        end
    endgenerate

    gclk_clk_map #(.NCLK(NUM_CLK), .NGEN(NUM_GEN)) u_map (
        .clk      (clk),
        .rst      (rst),
        .swrst    (swrst),
        .we       (clk_we),
        .wdata    (clk_wdata),
        .gen_tick (gen_tick),
        .clk_en   (clk_en)
    );

    assign main_clk_en = gen_tick[0];

endmodule

// File: tb/tb_gclk_ctrl.sv
module tb_gclk_ctrl;
    import gclk_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst = 1'b1, swrst = 1'b0, gen_we = 1'b0, clk_we = 1'b0;
    logic [GEN_IDW-1:0] gen_wid = '0;
    logic [CFG_W-1:0]   gen_wdata = '0, clk_wdata = '0;
    logic [NUM_EXT-1:0] src_tick = '0;
    logic [NUM_GEN-1:0] gen_pad_in = '0;
    logic [NUM_GEN-1:0] gen_pad_out, gen_pad_oe, gen_tick, gen_active;
    logic               main_clk_en;
    logic [NUM_CLK-1:0] clk_en;

    gclk_ctrl dut (
        .clk(clk), .rst(rst), .swrst(swrst), .gen_we(gen_we), .gen_wid(gen_wid),
        .gen_wdata(gen_wdata), .clk_we(clk_we), .clk_wdata(clk_wdata),
        .src_tick(src_tick), .gen_pad_in(gen_pad_in), .gen_pad_out(gen_pad_out),
        .gen_pad_oe(gen_pad_oe), .gen_tick(gen_tick), .gen_active(gen_active),
        .main_clk_en(main_clk_en), .clk_en(clk_en)
    );

    int checks = 0, errors = 0;
    bit started = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_src [NUM_GEN], m_div [NUM_GEN], m_cnt [NUM_GEN];
    bit m_dsel [NUM_GEN], m_en [NUM_GEN], m_pad [NUM_GEN], m_lock [NUM_GEN], m_tick [NUM_GEN];
    int m_cgen [NUM_CLK];
    bit m_cen [NUM_CLK], m_clock [NUM_CLK];

    always @(posedge clk) begin : model
        bit nt [NUM_GEN];
        int code, d, cid, cg;
        bit s, don, wr, wipe;
        if (rst) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                m_src[g] = 0; m_div[g] = 0; m_cnt[g] = 0; m_dsel[g] = 0;
                m_en[g] = (g == 0); m_pad[g] = 0; m_lock[g] = 0; m_tick[g] = 0;
            end
            for (int c = 0; c < NUM_CLK; c++) begin
                m_cgen[c] = 0; m_cen[c] = 0; m_clock[c] = 0;
            end
        end else begin
            cid = int'(clk_wdata[5:0]);
            cg  = int'(clk_wdata[11:8]);
            for (int g = 0; g < NUM_GEN; g++) begin
                code = m_src[g];
                d    = m_div[g];
                don  = m_dsel[g] && d > 1;
                if (code < 6)       s = src_tick[code];
                else if (code == 6) s = gen_pad_in[g] && !m_pad[g];
                else                s = m_tick[1];
                nt[g] = m_en[g] && (don ? (s && m_cnt[g] == d - 1) : s);
                wipe = swrst && !m_lock[g];
                wr   = gen_we && int'(gen_wid) == g && !m_lock[g]
                       && !(g == 1 && gen_wdata[2:0] == 3'd7);
                if (wipe || wr) m_cnt[g] = 0;
                else if (s && don) m_cnt[g] = (m_cnt[g] == d - 1) ? 0 : m_cnt[g] + 1;
                if (wipe) begin
                    m_src[g] = 0; m_div[g] = 0; m_dsel[g] = 0;
                    m_en[g] = (g == 0); m_pad[g] = 0;
                end else if (wr) begin
                    m_src[g] = int'(gen_wdata[2:0]); m_dsel[g] = gen_wdata[3];
                    m_en[g] = gen_wdata[4]; m_pad[g] = gen_wdata[5];
                    m_lock[g] = gen_wdata[6]; m_div[g] = int'(gen_wdata[15:8]);
                end
            end
            for (int c = 0; c < NUM_CLK; c++) begin
                if (swrst && !m_clock[c]) begin
                    m_cgen[c] = 0; m_cen[c] = 0;
                end else if (clk_we && cid == c && cg < NUM_GEN && !m_clock[c]) begin
                    m_cgen[c] = cg; m_cen[c] = clk_wdata[14]; m_clock[c] = clk_wdata[15];
                end
            end
            for (int g = 0; g < NUM_GEN; g++) m_tick[g] = nt[g];
        end
    end

    always @(negedge clk) begin : compare
        logic [NUM_GEN-1:0] et, ea, eo;
        logic [NUM_CLK-1:0] ec;
        if (started) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                et[g] = m_tick[g]; ea[g] = m_en[g]; eo[g] = m_pad[g];
            end
            for (int c = 0; c < NUM_CLK; c++) ec[c] = m_cen[c] && m_tick[m_cgen[c]];
            check("R2 R3 R4 gen_tick", 32'(gen_tick), 32'(et));
            check("R5 gen_active", 32'(gen_active), 32'(ea));
            check("R7 gen_pad_oe", 32'(gen_pad_oe), 32'(eo));
            check("R7 gen_pad_out", 32'(gen_pad_out), 32'(eo & et));
            check("R11 main_clk_en", 32'(main_clk_en), 32'(et[0]));
            check("R8 R9 R10 clk_en", 32'(clk_en), 32'(ec));
        end
    end

    function automatic logic [15:0] gw(input int src, input bit dsel, input bit en,
                                       input bit pad, input bit lock, input int div);
        return {8'(div), 1'b0, lock, pad, en, dsel, 3'(src)};
    endfunction

    function automatic logic [15:0] cw(input int id, input int gen, input bit en, input bit lock);
        return {lock, en, 2'b00, 4'(gen), 2'b00, 6'(id)};
    endfunction

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic gwrite(input int id, input logic [15:0] w);
        step();
        gen_we = 1'b1; gen_wid = GEN_IDW'(id); gen_wdata = w;
        step();
        gen_we = 1'b0;
    endtask

    task automatic cwrite(input logic [15:0] w);
        step();
        clk_we = 1'b1; clk_wdata = w;
        step();
        clk_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        int cnt;
        @(posedge clk);
        started = 1;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        check("R1 gen_active", 32'(gen_active), 32'h1);
        check("R1 gen_pad_oe", 32'(gen_pad_oe), 32'h0);
        check("R1 clk_en", 32'(clk_en), 32'h0);
        src_tick = 6'b000001;
        step();
        step();
        check("R11 main runs on src 0", 32'(main_clk_en), 32'h1);

        // R2 pad source
        gwrite(2, gw(6, 0, 1, 0, 0, 0));
        gen_pad_in[2] = 1'b1; step(); gen_pad_in[2] = 1'b0;
        check("R2 pad source tick", 32'(gen_tick[2]), 32'h1);
        // R7 driven pad is not a source
        gwrite(2, gw(6, 0, 1, 1, 0, 0));
        gen_pad_in[2] = 1'b1; step(); gen_pad_in[2] = 1'b0;
        check("R7 driven pad no tick", 32'(gen_tick[2]), 32'h0);
        check("R7 pad_oe", 32'(gen_pad_oe[2]), 32'h1);
        // R2 channel 1 as source
        gwrite(1, gw(0, 0, 1, 0, 0, 0));
        gwrite(3, gw(7, 0, 1, 0, 0, 0));
        step(); step();
        check("R2 gen1 feeds gen3", 32'(gen_tick[3]), 32'h1);

        // R4 division
        gwrite(2, gw(0, 1, 1, 0, 0, 3));
        step(); step();
        cnt = 0;
        for (int k = 0; k < 9; k++) begin step(); cnt += int'(gen_tick[2]); end
        check("R4 divide by 3", 32'(cnt), 32'd3);
        gwrite(2, gw(0, 1, 1, 0, 0, 1));
        step();
        cnt = 0;
        for (int k = 0; k < 5; k++) begin step(); cnt += int'(gen_tick[2]); end
        check("R4 divide by 1", 32'(cnt), 32'd5);
        gwrite(2, gw(0, 1, 1, 0, 0, 0));
        step();
        cnt = 0;
        for (int k = 0; k < 5; k++) begin step(); cnt += int'(gen_tick[2]); end
        check("R4 divide by 0", 32'(cnt), 32'd5);

        // R5 disable
        gwrite(2, gw(0, 0, 0, 0, 0, 0));
        check("R5 active cleared", 32'(gen_active[2]), 32'h0);
        step();
        check("R5 tick gated", 32'(gen_tick[2]), 32'h0);

        // R6 channel 1 self-select rejected
        gwrite(1, gw(0, 0, 0, 0, 0, 0));
        gwrite(1, gw(7, 0, 1, 0, 0, 0));
        check("R6 self select ignored", 32'(gen_active[1]), 32'h0);

        // R8 map and invalid writes
        cwrite(cw(2, 0, 1, 0));
        check("R8 entry 2 on gen0", 32'(clk_en[2]), 32'h1);
        cwrite(cw(3, 5, 1, 0));
        cwrite(cw(9, 0, 1, 0));
        check("R8 invalid writes ignored", 32'(clk_en), 32'h04);

        // R9 locks
        cwrite(cw(2, 0, 1, 1));
        cwrite(cw(2, 1, 0, 0));
        check("R9 locked entry kept", 32'(clk_en[2]), 32'h1);
        gwrite(3, gw(0, 0, 1, 0, 1, 0));
        gwrite(3, gw(0, 0, 0, 0, 0, 0));
        check("R9 locked gen kept", 32'(gen_active[3]), 32'h1);

        // R10 software reset spares locks
        gwrite(2, gw(0, 0, 1, 0, 0, 0));
        step(); swrst = 1'b1; step(); swrst = 1'b0;
        check("R10 swrst active", 32'(gen_active), 32'h9);
        check("R10 locked entry survives", 32'(clk_en[2]), 32'h1);
        step(); rst = 1'b1; step(); rst = 1'b0;
        check("R10 rst clears all", 32'(gen_active), 32'h1);
        gwrite(3, gw(0, 0, 1, 0, 0, 0));
        gwrite(3, gw(0, 0, 0, 0, 0, 0));
        check("R10 lock cleared by rst", 32'(gen_active[3]), 32'h0);

        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] w;
            step();
            src_tick   = NUM_EXT'($urandom);
            gen_pad_in = NUM_GEN'($urandom);
            gen_we     = ($urandom % 4) == 0;
            gen_wid    = GEN_IDW'($urandom);
            w          = 16'($urandom);
            w[15:8]    = 8'($urandom % 6);
            if ($urandom % 16 != 0) w[6] = 1'b0;
            gen_wdata  = w;
            clk_we     = ($urandom % 4) == 0;
            w          = 16'($urandom);
            w[5:0]     = 6'($urandom % 10);
            w[11:8]    = 4'($urandom % 6);
            if ($urandom % 16 != 0) w[15] = 1'b0;
            clk_wdata  = w;
            swrst      = ($urandom % 150) == 0;
            rst        = ($urandom % 700) == 0;
        end
        step();
        gen_we = 1'b0; clk_we = 1'b0; swrst = 1'b0; rst = 1'b0;
        repeat (4) step();
        finish_run();
    end

endmodule